// File: doc/BRIEF.md
# External Interrupt Line Conditioner

The block accepts a small set of asynchronous interrupt pins from outside the chip. It turns each pin into a request line toward a processor interrupt input. Each pin first passes through a flop synchronizer. A trigger detector then looks for the condition picked for that line: a high level, a low level, a rising edge, a falling edge, or either edge. Edge events are held in a sticky flag until software acknowledges them. Level conditions are passed through live. A per-line enable gates what reaches the pending outputs.

All control for all lines lives in one 32-bit configuration word, which is written and read through a single-register port. For each line the word holds an enable bit, a level-select bit, a polarity bit, an any-edge bit and a write-one acknowledge bit. The acknowledge bit is a pulse, not stored state. The same word, when read, also shows a per-line status field: the detected condition before the enable is applied. A reduction output signals that at least one line is pending.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every line is in active-low level mode with its enable clear. Bits [19:0] of the read word equal 20'h00F00, and no pending output is set.
- R2: The word written to `cfg_wdata` reads back with polarity in [3:0], any-edge in [7:4], level-select in [11:8] and enable in [19:16]. Bits [15:12] and [31:24] always read as zero.
- R3: With level-select = 1 and polarity = 1, an enabled line is pending while its synchronized pin is high. This takes effect two clock edges after the pin changes.
- R4: With level-select = 1 and polarity = 0, an enabled line is pending while its synchronized pin is low.
- R5: With level-select = 0, any-edge = 0 and polarity = 1, a rising pin edge sets a sticky flag. The line is pending on the third clock edge after the change, and it stays pending after the pin falls.
- R6: With level-select = 0, any-edge = 0 and polarity = 0, only falling edges set the flag. Rising edges leave the line idle.
- R7: With level-select = 0 and any-edge = 1, both rising and falling edges set the flag, whatever the polarity bit holds.
- R8: Writing 1 to a line's acknowledge bit in [15:12] clears its flag at that write's clock edge. If a new edge event falls on the same edge, the flag stays set.
- R9: A line whose enable is 0 never drives its pending output. An edge that arrives while the line is disabled is still latched, and it shows on the pending output as soon as the enable is written to 1.
- R10: In level mode, writing the acknowledge bit does not change the pending output, which keeps following the pin.
- R11: `irq_any` is high exactly when at least one `irq_pend` bit is high.
- R12: Read bits [23:20] show each line's detected condition (level match or latched edge) regardless of its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | REG_W | Configuration write data, including acknowledge pulses |
| cfg_rdata | output | REG_W | Configuration readback with status field |
| irq_pend | output | NUM_LINES | Per-line enabled request |
| irq_any | output | 1 | OR of all pending lines |

## Verification
Level-mode results reach `irq_pend` two rising edges after a pin change, the synchronizer delay. Edge-mode results take one edge more, because the previous-value register has to see the change. Configuration writes and acknowledges take effect at the edge that samples the strobe, so enable changes show on the following sample. The bench keeps a cycle model that advances on the same rising edges and compares every output on each falling edge. Directed sequences wait exactly two or three edges before their explicit checks, including the acknowledge written on the same edge as a fresh edge event.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Order of the per-line fields inside the configuration word.
   typedef enum int {
      FLD_POL    = 0,
      FLD_ANY    = 1,
      FLD_LEVEL  = 2,
      FLD_ACK    = 3,
      FLD_EN     = 4,
      FLD_STATUS = 5,
      FLD_COUNT  = 6
   } eirq_field_e;

   // Lowest bit of a field for a given line count.
   function automatic int fld_lo(input int lines, input eirq_field_e f);
      return lines * int'(f);
   endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   timeunit 1ns;
   timeprecision 1ps;

   if (STAGES < 2) begin : g_bad_stages
      $error("eirq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_line.sv
module eirq_line (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic pol,
   input  logic any_edge,
   input  logic level_sel,
   input  logic enable,
   input  logic ack,
   output logic latch_q,
   output logic raw,
   output logic pend
);
   timeunit 1ns;
   timeprecision 1ps;

   logic prev_q;
   logic rise, fall, edge_ev, level_hit;

   assign rise      = pin_s & ~prev_q;
   assign fall      = ~pin_s & prev_q;
   assign edge_ev   = any_edge ? (rise | fall) : (pol ? rise : fall);
   assign level_hit = (pin_s == pol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= pin_s;
         // A new event outranks an acknowledge in the same cycle.
         latch_q <= level_sel ? 1'b0 : (edge_ev | (latch_q & ~ack));
      end
   end

   assign raw  = level_sel ? level_hit : latch_q;
   assign pend = raw & enable;
endmodule

// File: rtl/eirq_cfg.sv
module eirq_cfg
   import eirq_pkg::*;
#(
   parameter int LINES = 4,
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic [LINES-1:0] status,
   output logic [REG_W-1:0] rdata,
   output logic [LINES-1:0] pol,
   output logic [LINES-1:0] any_edge,
   output logic [LINES-1:0] level_sel,
   output logic [LINES-1:0] enable,
   output logic [LINES-1:0] ack
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LO_POL = fld_lo(LINES, FLD_POL);
   localparam int LO_ANY = fld_lo(LINES, FLD_ANY);
   localparam int LO_LVL = fld_lo(LINES, FLD_LEVEL);
   localparam int LO_ACK = fld_lo(LINES, FLD_ACK);
   localparam int LO_EN  = fld_lo(LINES, FLD_EN);
   localparam int LO_ST  = fld_lo(LINES, FLD_STATUS);
   localparam int USED   = fld_lo(LINES, FLD_COUNT);

   if (USED > REG_W) begin : g_bad_width
      $error("eirq_cfg: fields do not fit the register");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol       <= '0;
         any_edge  <= '0;
         level_sel <= '1;
         enable    <= '0;
      end else if (wr) begin
         pol       <= wdata[LO_POL +: LINES];
         any_edge  <= wdata[LO_ANY +: LINES];
         level_sel <= wdata[LO_LVL +: LINES];
         enable    <= wdata[LO_EN  +: LINES];
      end
   end

   assign ack = wr ? wdata[LO_ACK +: LINES] : '0;

   always_comb begin
      rdata = '0;
      rdata[LO_POL +: LINES] = pol;
      rdata[LO_ANY +: LINES] = any_edge;
      rdata[LO_LVL +: LINES] = level_sel;
      rdata[LO_EN  +: LINES] = enable;
      rdata[LO_ST  +: LINES] = status;
   end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
   parameter int NUM_LINES   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int REG_W       = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_pin,
   input  logic                 cfg_wr,
   input  logic [REG_W-1:0]     cfg_wdata,
   output logic [REG_W-1:0]     cfg_rdata,
   output logic [NUM_LINES-1:0] irq_pend,
   output logic                 irq_any
);
   timeunit 1ns;
   timeprecision 1ps;

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("ext_irq_ctrl: NUM_LINES must be positive");
   end

   logic [NUM_LINES-1:0] pin_s;
   logic [NUM_LINES-1:0] cfg_pol, cfg_any, cfg_lvl, cfg_en, ack_pulse;
   logic [NUM_LINES-1:0] line_latch, line_raw;

   eirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (irq_pin),
      .sync_out (pin_s)
   );

   eirq_cfg #(.LINES(NUM_LINES), .REG_W(REG_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .wdata     (cfg_wdata),
      .status    (line_raw),
      .rdata     (cfg_rdata),
      .pol       (cfg_pol),
      .any_edge  (cfg_any),
      .level_sel (cfg_lvl),
      .enable    (cfg_en),
      .ack       (ack_pulse)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      eirq_line u_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_s     (pin_s[i]),
         .pol       (cfg_pol[i]),
         .any_edge  (cfg_any[i]),
         .level_sel (cfg_lvl[i]),
         .enable    (cfg_en[i]),
         .ack       (ack_pulse[i]),
         .latch_q   (line_latch[i]),
         .raw       (line_raw[i]),
         .pend      (irq_pend[i])
      );
   end

   assign irq_any = |irq_pend;
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
   parameter int N     = 4,
   parameter int REG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N-1:0]     pin_s,
   input logic [N-1:0]     latch,
   input logic [N-1:0]     pol,
   input logic [N-1:0]     any_edge,
   input logic [N-1:0]     level_sel,
   input logic [N-1:0]     enable,
   input logic [N-1:0]     ack,
   input logic [N-1:0]     pend,
   input logic             any_out,
   input logic [REG_W-1:0] rdata
);
   timeunit 1ns;
   timeprecision 1ps;

   for (genvar i = 0; i < N; i++) begin : g_chk
      AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(pin_s[i]) && !level_sel[i] && (pol[i] || any_edge[i])) |=> latch[i]); // R5
      AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(pin_s[i]) && !level_sel[i] && (!pol[i] || any_edge[i])) |=> latch[i]); // R6
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (latch[i] && !level_sel[i] && !ack[i]) |=> latch[i]); // R8
      AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (latch[i] && ack[i] && !level_sel[i] && $stable(pin_s[i])) |=> !latch[i]); // R8
      AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         level_sel[i] |=> !latch[i]); // R10
      AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
         !enable[i] |-> !pend[i]); // R9
   end

   AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      any_out == (pend != '0)); // R11
   AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[3*N +: N] == '0); // R2
endmodule

bind ext_irq_ctrl eirq_checker #(.N(NUM_LINES), .REG_W(REG_W)) u_eirq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pin_s     (pin_s),
   .latch     (line_latch),
   .pol       (cfg_pol),
   .any_edge  (cfg_any),
   .level_sel (cfg_lvl),
   .enable    (cfg_en),
   .ack       (ack_pulse),
   .pend      (irq_pend),
   .any_out   (irq_any),
   .rdata     (cfg_rdata)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] pins = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [N-1:0] pend;
   logic        any_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   ext_irq_ctrl i_ext_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_pin   (pins),
      .cfg_wr    (wr),
      .cfg_wdata (wdata),
      .cfg_rdata (rdata),
      .irq_pend  (pend),
      .irq_any   (any_o)
   );

   // ---------------- reference model from the requirements ----------------
   logic [N-1:0] m_s1, m_s2, m_prev, m_flag, m_pol, m_any, m_lvl, m_en;

   function automatic bit edge_hit(bit s, bit p, bit pol, bit anye);
      bit r = s & ~p;
      bit f = ~s & p;
      return anye ? (r | f) : (pol ? r : f);
   endfunction

   function automatic logic [N-1:0] m_raw();
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = m_lvl[i] ? (m_s2[i] == m_pol[i]) : m_flag[i];
      return r;
   endfunction

   function automatic logic [31:0] word(logic [3:0] pol, logic [3:0] anye,
                                        logic [3:0] lvl, logic [3:0] ack, logic [3:0] en);
      return {12'h000, en, ack, lvl, anye, pol};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flag <= '0;
         m_pol <= '0; m_any <= '0; m_lvl <= '1; m_en <= '0;
      end else begin
         for (int i = 0; i < N; i++)
            m_flag[i] <= m_lvl[i] ? 1'b0 :
               (edge_hit(m_s2[i], m_prev[i], m_pol[i], m_any[i]) | (m_flag[i] & ~(wr & wdata[12+i])));
         if (wr) begin
            m_pol <= wdata[3:0]; m_any <= wdata[7:4];
            m_lvl <= wdata[11:8]; m_en <= wdata[19:16];
         end
         m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic [N-1:0] ep = m_raw() & m_en;
      chk({tag, " pending R3/R4/R5/R6/R7/R9"}, 32'(pend), 32'(ep));
      chk({tag, " any R11"}, 32'(any_o), 32'(ep != '0));
      chk({tag, " readback R2/R12"}, rdata, {8'h00, m_raw(), m_en, 4'h0, m_lvl, m_any, m_pol});
   endtask

   task automatic tick(input string tag);
      @(negedge clk);
      compare(tag);
      wr = 1'b0;
      wdata = '0;
   endtask

   task automatic put(input logic [31:0] w);
      wr = 1'b1;
      wdata = w;
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      tick("R1");
      chk("R1 cfg after reset", {12'h0, rdata[19:0]}, 32'h00000F00);
      chk("R1 pend after reset", 32'(pend), 32'h0);

      put(32'hFFFF_FFFF); tick("R2");
      chk("R2 readback", {12'h0, rdata[19:0]}, 32'h000F0FFF);
      chk("R2 upper bits zero", {24'h0, rdata[31:24]}, 32'h0);

      // R3 level high
      put(word(4'hF, 4'h0, 4'hF, 4'h0, 4'hF)); tick("R3");
      pins = 4'b0101; tick("R3"); tick("R3");
      chk("R3 level high pend", 32'(pend), 32'h5);
      // R4 level low
      put(word(4'h0, 4'h0, 4'hF, 4'h0, 4'hF)); tick("R4");
      chk("R4 level low pend", 32'(pend), 32'hA);

      // R5 rising
      pins = 4'h0;
      put(word(4'hF, 4'h0, 4'h0, 4'hF, 4'hF)); tick("R5");
      repeat (3) tick("R5");
      put(word(4'hF, 4'h0, 4'h0, 4'hF, 4'hF)); tick("R5");
      chk("R5 clean start", 32'(pend), 32'h0);
      pins = 4'hF; repeat (3) tick("R5");
      chk("R5 rise latched", 32'(pend), 32'hF);
      pins = 4'h0; repeat (3) tick("R5");
      chk("R5 sticky after fall", 32'(pend), 32'hF);

      // R6 falling
      put(word(4'h0, 4'h0, 4'h0, 4'hF, 4'hF)); tick("R6");
      pins = 4'hF; repeat (4) tick("R6");
      chk("R6 rise ignored", 32'(pend), 32'h0);
      pins = 4'h0; repeat (3) tick("R6");
      chk("R6 fall latched", 32'(pend), 32'hF);

      // R7 both edges
      put(word(4'h5, 4'hF, 4'h0, 4'hF, 4'hF)); tick("R7");
      chk("R7 cleared", 32'(pend), 32'h0);
      pins = 4'b0011; repeat (3) tick("R7");
      chk("R7 rise", 32'(pend), 32'h3);
      put(word(4'h5, 4'hF, 4'h0, 4'h3, 4'hF)); tick("R7");
      pins = 4'b0000; repeat (3) tick("R7");
      chk("R7 fall", 32'(pend), 32'h3);

      // R8 acknowledge against a coincident edge
      put(word(4'hF, 4'h0, 4'h0, 4'hF, 4'hF)); tick("R8");
      repeat (3) tick("R8");
      chk("R8 idle", 32'(pend), 32'h0);
      pins = 4'b0001; tick("R8"); tick("R8");
      put(word(4'hF, 4'h0, 4'h0, 4'h1, 4'hF)); tick("R8");
      chk("R8 edge beats ack", 32'(pend), 32'h1);
      put(word(4'hF, 4'h0, 4'h0, 4'h1, 4'hF)); tick("R8");
      chk("R8 ack clears", 32'(pend), 32'h0);

      // R9 disabled edge kept
      put(word(4'hF, 4'h0, 4'h0, 4'hF, 4'h0)); tick("R9");
      pins = 4'b0011; repeat (4) tick("R9");
      chk("R9 masked", 32'(pend), 32'h0);
      put(word(4'hF, 4'h0, 4'h0, 4'h0, 4'hF)); tick("R9");
      chk("R9 shows on enable", 32'(pend), 32'h2);

      // R10 ack ignored in level mode
      put(word(4'hF, 4'h0, 4'hF, 4'h0, 4'hF)); tick("R10");
      pins = 4'hF; repeat (3) tick("R10");
      put(word(4'hF, 4'h0, 4'hF, 4'hF, 4'hF)); tick("R10");
      chk("R10 level unaffected", 32'(pend), 32'hF);
      chk("R11 any high", 32'(any_o), 32'h1);

      // R12 status ignores enable
      put(word(4'hF, 4'h0, 4'hF, 4'h0, 4'h0)); tick("R12");
      chk("R12 status", {28'h0, rdata[23:20]}, 32'hF);
      chk("R12 pend off", 32'(pend), 32'h0);
      chk("R11 any low", 32'(any_o), 32'h0);

      // Random phase, checked every cycle against the model
      for (int c = 0; c < 4000; c++) begin
         for (int i = 0; i < N; i++)
            if ($urandom_range(3) == 0) pins[i] = ~pins[i];
         case ($urandom_range(15))
            0: put($urandom() & 32'h000F_FFFF);
            1, 2: put(word(m_pol, m_any, m_lvl, 4'($urandom()), m_en));
            default: ;
         endcase
         tick("random");
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule